// File: doc/BRIEF.md
# Bitonic Counting Network Shared Counter

This block hands out unique, dense integer tickets to many requesters at once without a single counter register that every request must touch. Each of W input ports (W a power of two) may present a token per cycle. The tokens pass through a combinational network of two-input, two-output toggle balancers, built recursively from half-width networks and a merging stage. Each of the W output wires feeds its own counter. Together the counters hand out every integer exactly once.

Each token carries the index of the port it came in on. The value from the output counter is therefore returned to that port one cycle after acceptance. No single place serialises all requests. The network only guarantees that, once traffic has drained, the values handed out form the contiguous range 0 to T-1 for T tokens. It does not guarantee that those values follow the real-time order in which the requests arrived.

Top module: `cn_counter_net`

## Requirements
- R1: A balancer holds one toggle bit, which resets to 0. A single token leaves on output 0 when the toggle is 0 and on output 1 when it is 1, and the toggle then inverts. As a result, tokens sent one at a time from any ports after reset receive 0, 1, 2, ... in order.
- R2: When tokens reach both inputs of a balancer in the same cycle, both are taken. The token on input 0 leaves on the output that the toggle selects, the token on input 1 leaves on the other output, and the toggle keeps its value. After reset, simultaneous tokens on ports 0 and 1 receive 0 and 1 respectively, and the next single token receives 2.
- R3: The counter on output wire j starts at j and adds W for each token that leaves on that wire.
- R4: The network of width K is two networks of width K/2 followed by a merger of width K. The merger sends the even wires of the first half and the odd wires of the second half into one merger of width K/2, and sends the other wires into a second one. A final layer of balancers pairs output i of the two sub-mergers onto wires 2i and 2i+1. Tokens cross all (log2 W)(log2 W+1)/2 layers in the cycle in which they are accepted, so W tokens accepted together after reset receive exactly the values 0 to W-1.
- R5: Once every token has exited, the number of values handed out on each wire (value mod W) has the step property. Counts do not increase with the wire index, and the first and last wires differ by at most one.
- R6: Across any traffic pattern, the T values handed out are exactly 0 to T-1, with no value repeated and none missing.
- R7: A token accepted on port i in one cycle makes resp_valid[i] high with its value in the next cycle. resp_valid is low in every cycle that does not follow an acceptance on that port.
- R8: in_ready and resp_valid are low while rst_n is low. in_ready is high on every port from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | W | Token request, one bit per port |
| in_ready | output | W | Port can take a token this cycle |
| resp_valid | output | W | Ticket returned to the port this cycle |
| resp_value | output | W x VAL_W | Ticket value per port |

## Verification
The bench goes after simultaneous arrivals. Bad priority or toggle handling at a shared balancer shows up as a duplicated ticket or a hole in the range 0 to T-1. Wiring the merger with the wrong even/odd halves still returns values, but it breaks the step property of the per-wire counts after a burst drains, or it breaks the strict 0, 1, 2 sequence for one-at-a-time tokens. Random multi-cycle bursts on random port masks are drained and checked repeatedly, so an error in the counter stride or in routing the value back to the right port appears as a wrong residue, a wrong port, or a missed response.

// File: rtl/cn_pkg.sv
package cn_pkg;
   function automatic bit cn_is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/cn_balancer.sv
module cn_balancer #(
   parameter int TW = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          in_v,
   input  logic [1:0][TW-1:0]  in_tag,
   output logic [1:0]          out_v,
   output logic [1:0][TW-1:0]  out_tag
);
   logic toggle_q;
   logic single;

   assign single = in_v[0] ^ in_v[1];

   always_comb begin
      out_v   = '0;
      out_tag = '0;
      if (in_v == 2'b11) begin
         out_v             = 2'b11;
         out_tag[toggle_q]  = in_tag[0];
         out_tag[!toggle_q] = in_tag[1];
      end else if (single) begin
         out_v[toggle_q]   = 1'b1;
         out_tag[toggle_q] = in_v[0] ? in_tag[0] : in_tag[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) toggle_q <= 1'b0;
      else        toggle_q <= toggle_q ^ single;
   end

   // R1: a lone token inverts the toggle
   p_flip_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      single |=> (toggle_q != $past(toggle_q)));
   // R2: a pair leaves the toggle where it was
   p_pair_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v == 2'b11) |=> (toggle_q == $past(toggle_q)));
   // R6: tokens are neither created nor lost in a cell
   p_conserve_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(out_v) == $countones(in_v));
endmodule

// File: rtl/cn_merger.sv
module cn_merger #(
   parameter int K  = 8,
   parameter int TW = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [K-1:0]        in_v,
   input  logic [K-1:0][TW-1:0] in_tag,
   output logic [K-1:0]        out_v,
   output logic [K-1:0][TW-1:0] out_tag
);
   if (K == 2) begin : g_leaf
      cn_balancer #(.TW(TW)) u_bal (
         .clk(clk), .rst_n(rst_n), .in_v(in_v), .in_tag(in_tag),
         .out_v(out_v), .out_tag(out_tag));
   end else begin : g_split
      localparam int H = K / 2;
      localparam int Q = K / 4;
      logic [H-1:0]         a_iv, b_iv, a_ov, b_ov;
      logic [H-1:0][TW-1:0] a_it, b_it, a_ot, b_ot;

      for (genvar i = 0; i < Q; i++) begin : g_route
         // R4: even wires of first half with odd wires of second half
         assign a_iv[i]     = in_v[2*i];
         assign a_it[i]     = in_tag[2*i];
         assign a_iv[Q+i]   = in_v[H+2*i+1];
         assign a_it[Q+i]   = in_tag[H+2*i+1];
         assign b_iv[i]     = in_v[2*i+1];
         assign b_it[i]     = in_tag[2*i+1];
         assign b_iv[Q+i]   = in_v[H+2*i];
         assign b_it[Q+i]   = in_tag[H+2*i];
      end

      cn_merger #(.K(H), .TW(TW)) u_ma (
         .clk(clk), .rst_n(rst_n), .in_v(a_iv), .in_tag(a_it),
         .out_v(a_ov), .out_tag(a_ot));
      cn_merger #(.K(H), .TW(TW)) u_mb (
         .clk(clk), .rst_n(rst_n), .in_v(b_iv), .in_tag(b_it),
         .out_v(b_ov), .out_tag(b_ot));

      for (genvar i = 0; i < H; i++) begin : g_join
         cn_balancer #(.TW(TW)) u_bal (
            .clk(clk), .rst_n(rst_n),
            .in_v({b_ov[i], a_ov[i]}), .in_tag({b_ot[i], a_ot[i]}),
            .out_v(out_v[2*i+1:2*i]), .out_tag(out_tag[2*i+1:2*i]));
      end
   end
endmodule

// File: rtl/cn_bitonic.sv
module cn_bitonic #(
   parameter int K  = 8,
   parameter int TW = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [K-1:0]        in_v,
   input  logic [K-1:0][TW-1:0] in_tag,
   output logic [K-1:0]        out_v,
   output logic [K-1:0][TW-1:0] out_tag
);
   if (K == 2) begin : g_leaf
      cn_balancer #(.TW(TW)) u_bal (
         .clk(clk), .rst_n(rst_n), .in_v(in_v), .in_tag(in_tag),
         .out_v(out_v), .out_tag(out_tag));
   end else begin : g_split
      localparam int H = K / 2;
      logic [K-1:0]         mid_v;
      logic [K-1:0][TW-1:0] mid_t;

      cn_bitonic #(.K(H), .TW(TW)) u_lo (
         .clk(clk), .rst_n(rst_n),
         .in_v(in_v[H-1:0]), .in_tag(in_tag[H-1:0]),
         .out_v(mid_v[H-1:0]), .out_tag(mid_t[H-1:0]));
      cn_bitonic #(.K(H), .TW(TW)) u_hi (
         .clk(clk), .rst_n(rst_n),
         .in_v(in_v[K-1:H]), .in_tag(in_tag[K-1:H]),
         .out_v(mid_v[K-1:H]), .out_tag(mid_t[K-1:H]));
      cn_merger #(.K(K), .TW(TW)) u_merge (
         .clk(clk), .rst_n(rst_n), .in_v(mid_v), .in_tag(mid_t),
         .out_v(out_v), .out_tag(out_tag));
   end
endmodule

// File: rtl/cn_counter_net.sv
module cn_counter_net
   import cn_pkg::*;
#(
   parameter int W     = 8,
   parameter int VAL_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [W-1:0]           in_valid,
   output logic [W-1:0]           in_ready,
   output logic [W-1:0]           resp_valid,
   output logic [W-1:0][VAL_W-1:0] resp_value
);
   localparam int TW = $clog2(W);

   if (!cn_is_pow2(W)) begin : g_bad_width
      $error("cn_counter_net: W must be a power of two, at least 2");
   end
   if (VAL_W <= TW) begin : g_bad_val
      $error("cn_counter_net: VAL_W must exceed log2(W)");
   end

   logic                    ready_q;
   logic [W-1:0]            accept;
   logic [W-1:0][TW-1:0]    src_tag;
   logic [W-1:0]            exit_v;
   logic [W-1:0][TW-1:0]    exit_tag;
   logic [W-1:0][VAL_W-1:0] cnt_q;
   logic [W-1:0]            rv_d;
   logic [W-1:0][VAL_W-1:0] rval_d;

   assign in_ready = {W{ready_q}};
   assign accept   = in_valid & in_ready;

   for (genvar i = 0; i < W; i++) begin : g_tag
      assign src_tag[i] = TW'(i);
   end

   cn_bitonic #(.K(W), .TW(TW)) u_net (
      .clk(clk), .rst_n(rst_n), .in_v(accept), .in_tag(src_tag),
      .out_v(exit_v), .out_tag(exit_tag));

   always_comb begin
      rv_d   = '0;
      rval_d = '0;
      for (int j = 0; j < W; j++) begin
         if (exit_v[j]) begin
            rv_d[exit_tag[j]]   = 1'b1;
            rval_d[exit_tag[j]] = cnt_q[j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q    <= 1'b0;
         resp_valid <= '0;
         resp_value <= '0;
         for (int j = 0; j < W; j++) cnt_q[j] <= VAL_W'(j);
      end else begin
         ready_q    <= 1'b1;
         resp_valid <= rv_d;
         resp_value <= rval_d;
         for (int j = 0; j < W; j++)
            if (exit_v[j]) cnt_q[j] <= cnt_q[j] + VAL_W'(W);
      end
   end

   // R6: every accepted token exits the network in the same cycle
   p_exit_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(exit_v) == $countones(accept));

   for (genvar i = 0; i < W; i++) begin : g_chk
      // R7: response follows acceptance by one cycle
      p_resp_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
         accept[i] |=> resp_valid[i]);
      // R7: no response without a prior acceptance
      p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
         resp_valid[i] |-> $past(accept[i]));
   end
endmodule

// File: tb/tb_cn_counter_net.sv
module tb_cn_counter_net;
   localparam int W    = 8;
   localparam int VW   = 16;
   localparam int MAXT = 4096;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [W-1:0]         in_valid = '0;
   logic [W-1:0]         in_ready;
   logic [W-1:0]         resp_valid;
   logic [W-1:0][VW-1:0] resp_value;

   cn_counter_net #(.W(W), .VAL_W(VW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .resp_valid(resp_valid), .resp_value(resp_value));

   always #5 clk = ~clk;

   int n_run = 0, n_fail = 0;
   logic [W-1:0] prev_acc;
   bit  seen [MAXT];
   int  cnt_w [W];
   int  last_val [W];
   int  sent;

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic [W-1:0] mask);
      @(negedge clk);
      chk(resp_valid == prev_acc, "R7 response ports", int'(resp_valid), int'(prev_acc));
      for (int i = 0; i < W; i++) begin
         if (resp_valid[i]) begin
            int v = int'(resp_value[i]);
            last_val[i] = v;
            if (v >= MAXT || seen[v]) chk(1'b0, "R6 duplicate or range", v, -1);
            else begin
               seen[v] = 1'b1;
               cnt_w[v % W]++;
            end
         end
      end
      in_valid = mask;
      prev_acc = mask & in_ready;
      sent += $countones(prev_acc);
   endtask

   task automatic do_reset();
      rst_n    = 1'b0;
      in_valid = '0;
      prev_acc = '0;
      sent     = 0;
      foreach (seen[k]) seen[k] = 1'b0;
      foreach (cnt_w[k]) cnt_w[k] = 0;
      foreach (last_val[k]) last_val[k] = -1;
      repeat (3) @(negedge clk);
      chk(in_ready == '0, "R8 ready in reset", int'(in_ready), 0);
      chk(resp_valid == '0, "R8 resp in reset", int'(resp_valid), 0);
      rst_n = 1'b1;
   endtask

   task automatic check_drained(input string tag);
      int ok = 1;
      for (int j = 0; j + 1 < W; j++)
         if (cnt_w[j] < cnt_w[j+1]) ok = 0;
      if (cnt_w[0] - cnt_w[W-1] > 1) ok = 0;
      chk(ok == 1, {"R5 step ", tag}, cnt_w[0] - cnt_w[W-1], 1);
      ok = 1;
      for (int v = 0; v < sent; v++) if (!seen[v]) ok = 0;
      chk(ok == 1, {"R6 dense range ", tag}, sent, sent);
   endtask

   initial begin
      do_reset();
      step('0);
      chk(in_ready == '1, "R8 ready after reset", int'(in_ready), (1 << W) - 1);

      // R1 / R3: one token at a time gives 0,1,2,...
      for (int k = 0; k < 20; k++) begin
         int p = (3 * k) % W;
         step(W'(1) << p);
         step('0);
         chk(last_val[p] == k, "R1 sequential value", last_val[p], k);
      end
      check_drained("sequential");

      // R2: pair on ports 0 and 1
      do_reset();
      step(W'(3));
      step('0);
      chk(last_val[0] == 0, "R2 port0 of pair", last_val[0], 0);
      chk(last_val[1] == 1, "R2 port1 of pair", last_val[1], 1);
      step(W'(1) << 5);
      step('0);
      chk(last_val[5] == 2, "R2 token after pair", last_val[5], 2);

      // R4: all ports at once after reset
      do_reset();
      step('1);
      step('0);
      begin
         int sum = 0;
         for (int i = 0; i < W; i++) sum += last_val[i];
         chk(sum == W * (W - 1) / 2, "R4 full burst sum", sum, W * (W - 1) / 2);
      end
      check_drained("full burst");
      // R3: second full burst lands on the next stride
      step('1);
      step('0);
      for (int i = 0; i < W; i++)
         chk(last_val[i] >= W && last_val[i] < 2 * W, "R3 second stride", last_val[i], W);

      // R5 / R6: random bursts, drained and checked each time
      do_reset();
      for (int b = 0; b < 40; b++) begin
         int len = 1 + int'($urandom % 8);
         for (int c = 0; c < len; c++) step(W'($urandom));
         step('0);
         step('0);
         check_drained("random burst");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule